// File: doc/BRIEF.md
# Status Flags and Branch Condition Unit

This block keeps an 8-bit processor status register. The register holds four testable arithmetic flags: carry, zero, sign and overflow. It also holds two flags used only by decimal-adjust arithmetic (decimal and half-carry) and two general-purpose user bits.

The ALU updates the arithmetic flags through one write enable per flag. Software writes the user bits through a separate strobe. On interrupt or trap entry the whole register is presented for a push to the stack. On interrupt return, the value popped from the stack reloads the whole register.

A purely combinational evaluator takes the 4-bit condition field of a conditional jump opcode and says whether the jump is taken. It uses only carry, zero, sign and overflow. The ALU, the decoder, the stack memory and the program counter sit outside this block and appear only as ports.

Top module: `status_flag_unit`

## Requirements
- R1: Register bit layout is C=7, Z=6, S=5, V=4, D=3, H=2, F2=1, F1=0. An active-low reset (asynchronous) clears bits 7:2.
- R2: `aluWe[5:0]` and `aluVal[5:0]` map to register bits 7:2: index 5 is C, 4 is Z, 3 is S, 2 is V, 1 is D and 0 is H. On a clock edge, only flags whose enable is 1 take their new value.
- R3: Bits 1:0 change only on `userWe` (loading `userVal`) or on an interrupt-return load. ALU updates never change them.
- R4: Reset leaves bits 1:0 at their previous value.
- R5: In the same cycle that `trapEntry` is 1, `pushValid` is 1 and `pushData` equals the current register value.
- R6: When `popLoad` is 1, the next edge loads `popData` into all 8 bits. This load overrides any ALU or user write in the same cycle.
- R7: `condCode` carries opcode bits 7:4. Codes 0..7 mean never, S^V, Z|(S^V), C|Z, V, S, Z and C.
- R8: Codes 8..F are the complements of codes 0..7: always, GE, GT, UGT = !C&!Z, NOV, PL, NZ and NC.
- R9: D, H, F1 and F2 never affect `taken`.
- R10: `taken` follows the flags and `condCode` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aluWe | input | 6 | Per-flag ALU write enables (C..H) |
| aluVal | input | 6 | Per-flag ALU values (C..H) |
| userWe | input | 1 | Write strobe for the two user bits |
| userVal | input | 2 | New value for F2,F1 |
| popLoad | input | 1 | Interrupt-return load strobe |
| popData | input | 8 | Value popped from the stack |
| trapEntry | input | 1 | Interrupt, software trap or illegal-instruction trap entry |
| pushValid | output | 1 | Push request toward the stack |
| pushData | output | 8 | Register value to push |
| condCode | input | 4 | Condition field of the jump opcode |
| taken | output | 1 | Jump taken |
| flagsOut | output | 8 | Current register value |

## Verification
The evaluator is swept over every code. For each code the bench loads all 64 combinations of C, Z, S, V, D and H. This separates each predicate from its complement and from its neighbours, and it shows that D and H have no influence on `taken`.

Single-flag enables with alternating values show that each enable reaches only its own bit. A random mix of ALU writes, user writes, pops and traps, checked against a behavioural model every cycle, exposes wrong write priorities.

A pop issued together with ALU and user writes confirms that the load wins. A reset issued after a user write confirms that the user bits survive reset.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;
  localparam int FLAG_W  = 8;
  localparam int USER_N  = 2;
  localparam int ARITH_N = FLAG_W - USER_N;
  localparam int COND_W  = 4;
  localparam int BIT_C = 7;
  localparam int BIT_Z = 6;
  localparam int BIT_S = 5;
  localparam int BIT_V = 4;

  typedef struct packed {
    logic               loadAll;
    logic [ARITH_N-1:0] arithWrite;
    logic               userWrite;
    logic               pushReq;
  } flagStrobes_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import status_flag_pkg::*;
(
  input  logic [ARITH_N-1:0] aluWe,
  input  logic               userWe,
  input  logic               popLoad,
  input  logic               trapEntry,
  output flagStrobes_t       strobes
);
  // Interrupt-return load takes priority over every other writer.
  always_comb begin
    strobes.loadAll    = popLoad;
    strobes.arithWrite = popLoad ? '0 : aluWe;
    strobes.userWrite  = userWe & ~popLoad;
    strobes.pushReq    = trapEntry;
  end
endmodule

// File: rtl/flag_dp.sv
module flag_dp
  import status_flag_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  flagStrobes_t       strobes,
  input  logic [ARITH_N-1:0] aluVal,
  input  logic [USER_N-1:0]  userVal,
  input  logic [FLAG_W-1:0]  popData,
  output logic [FLAG_W-1:0]  flags,
  output logic               pushValid,
  output logic [FLAG_W-1:0]  pushData
);
  logic [ARITH_N-1:0] arithQ;
  logic [USER_N-1:0]  userQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arithQ <= '0;
    end else begin
      for (int i = 0; i < ARITH_N; i++) begin
        if (strobes.loadAll)            arithQ[i] <= popData[i+USER_N];
        else if (strobes.arithWrite[i]) arithQ[i] <= aluVal[i];
      end
    end
  end

  // User bits carry no reset on purpose.
  always_ff @(posedge clk) begin
    if (strobes.loadAll)        userQ <= popData[USER_N-1:0];
    else if (strobes.userWrite) userQ <= userVal;
  end

  assign flags     = {arithQ, userQ};
  assign pushValid = strobes.pushReq;
  assign pushData  = flags;

  genvar g;
  generate
    for (g = 0; g < ARITH_N; g++) begin : g_hold
      p_arith_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
        (!strobes.loadAll && !strobes.arithWrite[g]) |=> $stable(arithQ[g]))
        else $error("arith flag %0d changed without enable", g);
    end
  endgenerate

  p_user_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadAll && !strobes.userWrite) |=> $stable(userQ))
    else $error("user bits changed without write");
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import status_flag_pkg::*;
(
  input  logic [COND_W-1:0] code,
  input  logic              fC,
  input  logic              fZ,
  input  logic              fS,
  input  logic              fV,
  output logic              taken
);
  logic [7:0] basePred;
  logic       lessThan;

  always_comb begin
    lessThan    = fS ^ fV;
    basePred[0] = 1'b0;
    basePred[1] = lessThan;
    basePred[2] = fZ | lessThan;
    basePred[3] = fC | fZ;
    basePred[4] = fV;
    basePred[5] = fS;
    basePred[6] = fZ;
    basePred[7] = fC;
    // Upper half of the code space inverts the lower half.
    taken = basePred[code[COND_W-2:0]] ^ code[COND_W-1];
  end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import status_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  aluWe,
  input  logic [5:0]  aluVal,
  input  logic        userWe,
  input  logic [1:0]  userVal,
  input  logic        popLoad,
  input  logic [7:0]  popData,
  input  logic        trapEntry,
  output logic        pushValid,
  output logic [7:0]  pushData,
  input  logic [3:0]  condCode,
  output logic        taken,
  output logic [7:0]  flagsOut
);
  flagStrobes_t strobes;

  flag_ctrl u_ctrl (
    .aluWe(aluWe), .userWe(userWe), .popLoad(popLoad),
    .trapEntry(trapEntry), .strobes(strobes)
  );

  flag_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .aluVal(aluVal),
    .userVal(userVal), .popData(popData), .flags(flagsOut),
    .pushValid(pushValid), .pushData(pushData)
  );

  cond_eval u_cond (
    .code(condCode), .fC(flagsOut[BIT_C]), .fZ(flagsOut[BIT_Z]),
    .fS(flagsOut[BIT_S]), .fV(flagsOut[BIT_V]), .taken(taken)
  );

  p_pop_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    popLoad |=> flagsOut == $past(popData))
    else $error("pop load not applied");

  p_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    trapEntry |-> (pushValid && pushData == flagsOut))
    else $error("push value mismatch");

  p_zero_test_r7: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == 4'h6) |-> (taken == flagsOut[BIT_Z]))
    else $error("zero test wrong");

  p_never_r7: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == 4'h0) |-> !taken)
    else $error("never code taken");

  p_always_r8: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == 4'h8) |-> taken)
    else $error("always code not taken");
endmodule

// File: tb/sim_status_flag_unit.sv
module sim_status_flag_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] aluWe = '0, aluVal = '0;
  logic       userWe = 1'b0;
  logic [1:0] userVal = '0;
  logic       popLoad = 1'b0;
  logic [7:0] popData = '0;
  logic       trapEntry = 1'b0;
  logic [3:0] condCode = '0;
  logic       pushValid, taken;
  logic [7:0] pushData, flagsOut;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mFlags = '0;
  bit uKnown = 0;

  always #4 clk = ~clk;

  status_flag_unit u0 (
    .clk(clk), .rstN(rstN), .aluWe(aluWe), .aluVal(aluVal), .userWe(userWe),
    .userVal(userVal), .popLoad(popLoad), .popData(popData),
    .trapEntry(trapEntry), .pushValid(pushValid), .pushData(pushData),
    .condCode(condCode), .taken(taken), .flagsOut(flagsOut)
  );

  function automatic bit refTaken(input int code, input bit c, z, s, v);
    case (code)
      0: return 0;
      1: return s != v;
      2: return z || (s != v);
      3: return c || z;
      4: return v;
      5: return s;
      6: return z;
      7: return c;
      8: return 1;
      9: return s == v;
      10: return !z && (s == v);
      11: return !c && !z;
      12: return !v;
      13: return !s;
      14: return !z;
      default: return !c;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp, input logic [7:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act & mask, exp & mask);
    end
  endtask

  function automatic logic [7:0] knownMask();
    return uKnown ? 8'hFF : 8'hFC;
  endfunction

  // Called at a falling edge; drives, checks combinational outputs, clocks, checks register.
  task automatic cyc(input logic [5:0] we, input logic [5:0] av, input bit uw,
                     input logic [1:0] uv, input bit pl, input logic [7:0] pd,
                     input bit tr, input logic [3:0] cc, input string req);
    aluWe = we; aluVal = av; userWe = uw; userVal = uv;
    popLoad = pl; popData = pd; trapEntry = tr; condCode = cc;
    #1;
    chk("R10", "taken", {7'd0, taken},
        {7'd0, refTaken(int'(cc), mFlags[7], mFlags[6], mFlags[5], mFlags[4])}, 8'h01);
    chk("R5", "pushValid", {7'd0, pushValid}, {7'd0, tr}, 8'h01);
    if (tr) chk("R5", "pushData", pushData, mFlags, knownMask());
    @(posedge clk);
    if (pl) begin
      mFlags = pd; uKnown = 1;
    end else begin
      for (int i = 0; i < 6; i++) if (we[i]) mFlags[i+2] = av[i];
      if (uw) begin mFlags[1:0] = uv; uKnown = 1; end
    end
    @(negedge clk);
    chk(req, "flags", flagsOut, mFlags, knownMask());
  endtask

  task automatic doReset();
    rstN = 1'b0;
    #1;
    mFlags[7:2] = '0;
    chk("R1", "reset arith bits", flagsOut, mFlags, 8'hFC);
    chk("R4", "user bits across reset", flagsOut, mFlags, knownMask() & 8'h03);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    chk("R1", "reset state", flagsOut, 8'h00, 8'hFC);
    rstN = 1'b1;
    cyc('0, '0, 1, 2'b10, 0, '0, 0, 4'h0, "R3");
    for (int i = 0; i < 6; i++) begin
      cyc(6'd1 << i, 6'h3F, 0, '0, 0, '0, 0, 4'h8, "R2");
      cyc(6'd1 << i, 6'h00, 0, '0, 0, '0, 0, 4'h8, "R2");
      cyc(6'd1 << i, 6'h3F ^ (6'd1 << i), 0, '0, 0, '0, 0, 4'h0, "R2");
    end
    cyc(6'h3F, 6'h2A, 0, 2'b01, 0, '0, 0, 4'h3, "R3");
    cyc('0, '0, 1, 2'b01, 0, '0, 1, 4'h7, "R5");
    doReset();
    cyc('0, '0, 0, '0, 0, '0, 1, 4'h0, "R4");
    cyc(6'h3F, 6'h3F, 1, 2'b10, 1, 8'h5A, 0, 4'h9, "R6");
    cyc(6'h15, 6'h2A, 0, '0, 1, 8'hC3, 1, 4'hE, "R6");
    for (int n = 0; n < 400; n++) begin
      cyc(6'($urandom), 6'($urandom), ($urandom % 3) == 0, 2'($urandom),
          ($urandom % 8) == 0, 8'($urandom), ($urandom % 4) == 0,
          4'($urandom), "R2");
      if (n == 200) doReset();
    end
    for (int combo = 0; combo < 64; combo++) begin
      cyc('0, '0, 0, '0, 1, {6'(combo), 2'b01}, 0, 4'h0, "R6");
      for (int code = 0; code < 16; code++)
        cyc('0, '0, 0, '0, 0, '0, 0, 4'(code), code < 8 ? "R7" : "R8");
    end
    cyc('0, '0, 0, '0, 1, 8'b0000_1111, 0, 4'h0, "R9");
    for (int code = 0; code < 16; code++)
      cyc('0, '0, 0, '0, 0, '0, 0, 4'(code), "R9");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog none actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule